// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register File

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host reaches it through a parallel bus made of a 12-bit data word, a 2-bit channel address, an active-low select, a read/write line, an active-low load strobe and an active-low clear. Each channel keeps two registers. The input register is staged from the bus. The output register holds the code that the converter ladder would show. The four output codes leave the block as one flat port, with channel A in the lowest 12 bits.

The load strobe has two meanings, and chip select decides which one applies. When the block is selected, a low load strobe makes the addressed channel transparent: one write lands in both of its registers. When the block is deselected, a low load strobe copies every input register into its output register at the same moment, so all four channels update together. The clear input works whether or not the block is selected. It forces every register to a reset code chosen by a parameter: mid-scale 0x800, which gives zero output with a symmetric bipolar reference, or zero scale 0x000.

The bus is modelled as separate data-in, data-out and output-enable signals, and everything runs on one system clock. Every host input passes through a two-flop synchronizer before it is decoded. A registered effect therefore appears on the third rising clock edge after the inputs change. The output value of a channel follows low reference + (high − low) × N / 4096, where N is the straight-binary code with bit 11 as the MSB.

Top module: `qdac_regfile`

## Requirements
- R1: Address 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel k's output code sits at `out_codes[12k+11:12k]`.
- R2: While `cs_n` is high and `load_n` is high, no register changes and `data_oe` stays low, whatever `rd_wr`, `addr` and `data_in` carry.
- R3: `cs_n`=0, `rd_wr`=0, `load_n`=1 stores `data_in` in the addressed input register only. All output codes hold.
- R4: `cs_n`=0, `rd_wr`=0, `load_n`=0 stores `data_in` in both the input and output registers of the addressed channel. The other channels hold.
- R5: `cs_n`=0, `rd_wr`=1, `load_n`=1 raises `data_oe` and drives the addressed input register onto `data_out`. No register changes.
- R6: `cs_n`=1 with `load_n`=0 copies all four input registers into their output registers in the same cycle.
- R7: `clear_n`=0 forces every input and output register to the reset code and drops `data_oe`, whatever `cs_n` is. Clear wins over any simultaneous write or load.
- R8: The reset code is 0x800 when `MID_RESET`=1 (the default) and 0x000 when it is 0.
- R9: `data_oe` is high only for a readback. `cs_n`=0, `rd_wr`=1, `load_n`=0 is a no-op: no register changes and the bus is not driven.
- R10: Every effect of an input change appears on the third rising clock edge after the change (SYNC_STAGES + 1) and not earlier.
- R11: Synchronous `rst_n`=0 loads the reset code into all registers and holds `data_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clear_n | input | 1 | Active-low clear to the reset code, independent of select |
| cs_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = readback, 0 = write |
| load_n | input | 1 | Active-low load strobe |
| addr | input | 2 | Channel address (0 = A … 3 = D) |
| data_in | input | 12 | Bus data from the host |
| data_out | output | 12 | Readback data |
| data_oe | output | 1 | High while the block drives the bus |
| out_codes | output | 48 | Output-register codes, channel A in bits 11:0 |

## Verification
Two synchronizer flops lie in front of the decoder and one register stage lies behind it. So the output codes, `data_out` and `data_oe` all change on the third rising edge after the bench drives its inputs. The bench drives on a falling edge, waits three rising edges, and samples on the following falling edge. It then drives an idle bus and waits the same three edges before it samples again. This confirms that readback enable drops and that the output codes stay put. Every operation is held until its sample is taken, so repeated application of the same write or load inside the pipeline window is harmless and the expected value is unambiguous.

// File: rtl/qdac_pkg.sv
// Shared types for the quad converter register file.
package qdac_pkg;
    // Decoded bus operation, one per clock after synchronization.
    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_WR_IN    = 3'd1,
        OP_WR_THRU  = 3'd2,
        OP_READ     = 3'd3,
        OP_UPDATE   = 3'd4,
        OP_CLEAR    = 3'd5
    } qdac_op_e;
endpackage

// File: rtl/qdac_sync.sv
// Multi-stage synchronizer for a bundle of host inputs.
// Assumes the bundle settles well inside a clock period, so that all bits
// land in the same cycle. RST_VAL is the idle value loaded on reset.
module qdac_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture of the asynchronous bundle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Further resolution stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/qdac_decode.sv
// Combinational decoder from synchronized bus controls to one operation
// and a one-hot channel select. Clear has priority over every other op.
module qdac_decode
    import qdac_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int A_W  = 2
) (
    input  logic            cs_n,
    input  logic            rd_wr,
    input  logic            load_n,
    input  logic            clear_n,
    input  logic [A_W-1:0]  addr,
    output qdac_op_e        op,
    output logic [N_CH-1:0] ch_sel
);
    // Select the operation by priority: clear, selected access, broadcast.
    always_comb begin
        if (!clear_n)               op = OP_CLEAR;
        else if (!cs_n) begin
            if (!rd_wr)             op = load_n ? OP_WR_IN : OP_WR_THRU;
            else if (load_n)        op = OP_READ;
            else                    op = OP_IDLE;
        end
        else if (!load_n)           op = OP_UPDATE;
        else                        op = OP_IDLE;
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_sel
            assign ch_sel[c] = (addr == A_W'(c));
        end
    endgenerate
endmodule

// File: rtl/qdac_chan.sv
// One channel: an input register staged from the bus and an output
// register that feeds the converter. Assumes at most one of the write
// strobes matters per cycle; clear overrides them all.
module qdac_chan #(
    parameter int                CODE_W   = 12,
    parameter logic [CODE_W-1:0] RST_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_in,
    input  logic              wr_out,
    input  logic              upd,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] in_q,
    output logic [CODE_W-1:0] out_q
);
    // Input register: loaded by any write to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) in_q <= RST_CODE;
        else if (wr_in)      in_q <= din;
    end

    // Output register: transparent write or broadcast copy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) out_q <= RST_CODE;
        else if (wr_out)     out_q <= din;
        else if (upd)        out_q <= in_q;
    end
endmodule

// File: rtl/qdac_readback.sv
// Registered readback path: picks the addressed input register and drives
// the bus enable only for a readback operation.
module qdac_readback #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 12,
    parameter int A_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [A_W-1:0]           addr,
    input  logic [N_CH*CODE_W-1:0]   in_flat,
    output logic [CODE_W-1:0]        data_out,
    output logic                     data_oe
);
    logic [CODE_W-1:0] sel_code;

    // Pick the addressed channel's input code.
    always_comb begin
        sel_code = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (addr == A_W'(c)) sel_code = in_flat[c*CODE_W +: CODE_W];
        end
    end

    // Register the bus value and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            data_oe  <= 1'b0;
        end else begin
            data_out <= rd_en ? sel_code : '0;
            data_oe  <= rd_en;
        end
    end
endmodule

// File: rtl/qdac_regfile.sv
// Quad double-buffered converter register file. Host controls and data are
// synchronized, decoded into one operation per clock and applied to four
// channel register pairs. Assumes host inputs are quasi-static over
// SYNC_STAGES+1 clocks per access.
module qdac_regfile
    import qdac_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit MID_RESET   = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear_n,
    input  logic                       cs_n,
    input  logic                       rd_wr,
    input  logic                       load_n,
    input  logic [$clog2(N_CH)-1:0]    addr,
    input  logic [CODE_W-1:0]          data_in,
    output logic [CODE_W-1:0]          data_out,
    output logic                       data_oe,
    output logic [N_CH*CODE_W-1:0]     out_codes
);
    localparam int A_W = $clog2(N_CH);
    localparam int BUS_W = 4 + A_W + CODE_W;
    localparam logic [CODE_W-1:0] RST_CODE =
        MID_RESET ? CODE_W'(1) << (CODE_W - 1) : '0;
    localparam logic [BUS_W-1:0] IDLE_BUS = {4'b1111, {A_W{1'b0}}, {CODE_W{1'b0}}};

    logic [BUS_W-1:0]        bus_sync;
    logic                    s_clear_n, s_cs_n, s_load_n, s_rd_wr;
    logic [A_W-1:0]          s_addr;
    logic [CODE_W-1:0]       s_data;
    qdac_op_e                op;
    logic [N_CH-1:0]         ch_sel;
    logic [N_CH*CODE_W-1:0]  in_codes;

    qdac_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_BUS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({clear_n, cs_n, load_n, rd_wr, addr, data_in}),
        .dout (bus_sync)
    );

    assign {s_clear_n, s_cs_n, s_load_n, s_rd_wr, s_addr, s_data} = bus_sync;

    qdac_decode #(.N_CH(N_CH), .A_W(A_W)) u_dec (
        .cs_n   (s_cs_n),
        .rd_wr  (s_rd_wr),
        .load_n (s_load_n),
        .clear_n(s_clear_n),
        .addr   (s_addr),
        .op     (op),
        .ch_sel (ch_sel)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            qdac_chan #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (op == OP_CLEAR),
                .wr_in (ch_sel[c] && (op == OP_WR_IN || op == OP_WR_THRU)),
                .wr_out(ch_sel[c] && (op == OP_WR_THRU)),
                .upd   (op == OP_UPDATE),
                .din   (s_data),
                .in_q  (in_codes[c*CODE_W +: CODE_W]),
                .out_q (out_codes[c*CODE_W +: CODE_W])
            );
        end
    endgenerate

    qdac_readback #(.N_CH(N_CH), .CODE_W(CODE_W), .A_W(A_W)) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (op == OP_READ),
        .addr    (s_addr),
        .in_flat (in_codes),
        .data_out(data_out),
        .data_oe (data_oe)
    );
endmodule

// File: rtl/qdac_checker.sv
// Temporal checks on the register file, attached by bind. Relates the
// synchronized controls to register and bus state one clock later.
module qdac_checker #(
    parameter int                CODE_W   = 12,
    parameter int                N_CH     = 4,
    parameter int                A_W      = 2,
    parameter logic [CODE_W-1:0] RST_CODE = '0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      s_clear_n,
    input logic                      s_cs_n,
    input logic                      s_load_n,
    input logic                      s_rd_wr,
    input logic [A_W-1:0]            s_addr,
    input logic [CODE_W-1:0]         s_data,
    input logic [N_CH*CODE_W-1:0]    in_codes,
    input logic [N_CH*CODE_W-1:0]    out_codes,
    input logic                      data_oe
);
    assert_deselect_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_clear_n && s_cs_n && s_load_n) |=> ($stable(out_codes) && $stable(in_codes) && !data_oe));

    assert_input_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_clear_n && !s_cs_n && !s_rd_wr && s_load_n) |=> $stable(out_codes));

    assert_broadcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_clear_n && s_cs_n && !s_load_n) |=> (out_codes == $past(in_codes)));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_clear_n) |=> (out_codes == {N_CH{RST_CODE}} && in_codes == {N_CH{RST_CODE}} && !data_oe));

    assert_oe_only_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(s_clear_n && !s_cs_n && s_rd_wr && s_load_n));

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_chk
            assert_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (s_clear_n && !s_cs_n && !s_rd_wr && !s_load_n && s_addr == A_W'(c))
                |=> (out_codes[c*CODE_W +: CODE_W] == $past(s_data)));
        end
    endgenerate
endmodule

bind qdac_regfile qdac_checker #(
    .CODE_W(CODE_W), .N_CH(N_CH), .A_W(A_W), .RST_CODE(RST_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_clear_n(s_clear_n),
    .s_cs_n   (s_cs_n),
    .s_load_n (s_load_n),
    .s_rd_wr  (s_rd_wr),
    .s_addr   (s_addr),
    .s_data   (s_data),
    .in_codes (in_codes),
    .out_codes(out_codes),
    .data_oe  (data_oe)
);

// File: tb/qdac_regfile_tb.sv
module qdac_regfile_tb;
    localparam int W = 12;
    localparam logic [W-1:0] RST = 12'h800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_n = 1'b1, cs_n = 1'b1, rd_wr = 1'b1, load_n = 1'b1;
    logic [1:0] addr = '0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] data_out;
    logic data_oe;
    logic [4*W-1:0] out_codes;

    int n_tests = 0;
    int n_fail = 0;
    logic [W-1:0] m_in [4];
    logic [W-1:0] m_out [4];

    always #5 clk = ~clk;

    qdac_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .cs_n(cs_n), .rd_wr(rd_wr),
        .load_n(load_n), .addr(addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .out_codes(out_codes)
    );

    function automatic logic [4*W-1:0] model_flat();
        return {m_out[3], m_out[2], m_out[1], m_out[0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access, wait for the 3-edge latency (R10), check, then idle.
    task automatic do_op(input logic c, input logic rw, input logic ld, input logic clr,
                         input logic [1:0] a, input logic [W-1:0] d, input string req);
        logic exp_oe;
        logic [W-1:0] exp_rd;
        @(negedge clk);
        cs_n = c; rd_wr = rw; load_n = ld; clear_n = clr; addr = a; data_in = d;
        // R10: nothing may change after only two edges.
        repeat (2) @(posedge clk);
        @(negedge clk);
        check({req, " R10 early"}, 64'(out_codes), 64'(model_flat()));
        exp_oe = 1'b0; exp_rd = '0;
        if (!clr) begin
            for (int i = 0; i < 4; i++) begin m_in[i] = RST; m_out[i] = RST; end
        end else if (!c) begin
            if (!rw) begin
                m_in[a] = d;
                if (!ld) m_out[a] = d;
            end else if (ld) begin
                exp_oe = 1'b1; exp_rd = m_in[a];
            end
        end else if (!ld) begin
            for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " R1 R10 codes"}, 64'(out_codes), 64'(model_flat()));
        check({req, " R9 oe"}, 64'(data_oe), 64'(exp_oe));
        if (exp_oe) check({req, " R5 readback"}, 64'(data_out), 64'(exp_rd));
        cs_n = 1'b1; rd_wr = 1'b1; load_n = 1'b1; clear_n = 1'b1;
        data_in = ~d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({req, " R2 idle codes"}, 64'(out_codes), 64'(model_flat()));
        check({req, " R9 idle oe"}, 64'(data_oe), 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 4; i++) begin m_in[i] = RST; m_out[i] = RST; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11 / R8: reset state is mid-scale, bus idle.
        check("R11 R8 reset codes", 64'(out_codes), 64'({4{RST}}));
        check("R11 reset oe", 64'(data_oe), 64'd0);
        rst_n = 1'b1;

        // Directed corner cases.
        do_op(1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 12'h000, "R8 read reset code");
        do_op(1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 12'hABC, "R3 write input C");
        do_op(1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 12'h000, "R5 read C");
        do_op(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 12'hFFF, "R4 thru D max");
        do_op(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 12'h000, "R4 thru A zero");
        do_op(1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 12'h123, "R3 write input B");
        do_op(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 12'h777, "R2 deselected write");
        do_op(1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 12'h000, "R2 deselected read");
        do_op(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 12'h555, "R9 read with load");
        do_op(1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 12'h000, "R5 read B");
        do_op(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 12'h000, "R6 broadcast");
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 12'h3C3, "R7 clear beats write");
        do_op(1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 12'h000, "R7 read after clear");
        do_op(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 12'h000, "R7 clear deselected");

        // Constrained random accesses.
        void'($urandom(32'd2024));
        for (int k = 0; k < 150; k++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            case (r)
                4'd0:                      do_op(1'b0, 1'b0, 1'b0, 1'b0, 2'($urandom), 12'($urandom), "R7 rand clear");
                4'd1, 4'd2, 4'd3:          do_op(1'b0, 1'b0, 1'b1, 1'b1, 2'($urandom), 12'($urandom), "R3 rand write");
                4'd4, 4'd5:                do_op(1'b0, 1'b0, 1'b0, 1'b1, 2'($urandom), 12'($urandom), "R4 rand thru");
                4'd6, 4'd7, 4'd8:          do_op(1'b0, 1'b1, 1'b1, 1'b1, 2'($urandom), 12'($urandom), "R5 rand read");
                4'd9, 4'd10:               do_op(1'b1, 1'($urandom), 1'b0, 1'b1, 2'($urandom), 12'($urandom), "R6 rand update");
                4'd11:                     do_op(1'b0, 1'b1, 1'b0, 1'b1, 2'($urandom), 12'($urandom), "R9 rand read-load");
                default:                   do_op(1'b1, 1'($urandom), 1'b1, 1'b1, 2'($urandom), 12'($urandom), "R2 rand deselect");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule